// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

This block holds two 16-bit down-counting interval timers, A and B. Each has its own reload latch and its own control byte. The processor side writes single bytes into the block: the low half of a latch, the high half of a latch, or a control byte. All timer activity advances only on cycles where the system clock enable is high.

On reaching the end of its count, a timer reloads from its latch and raises a one-cycle underflow flag for an interrupt controller. It either carries on counting or, in one-shot mode, halts. Timer B can count system cycles, or it can count the underflows of timer A, which gives one 32-bit interval.

Start, stop and force-load requests pass through a cycle-exact sequencing machine. A control write lands one enabled cycle after its strobe. A newly started timer idles for one cycle before it counts. Every reload spends one cycle with no decrement. Each timer can also drive one port pin, either as a one-cycle pulse after underflow or as a level that flips on each underflow.

Top module: `dual_interval_timer`

## Requirements
- R1: Timer state (counters, control bytes, toggles, underflow flags) advances only on clock edges where `tick_en` is 1. With `tick_en` at 0 and no write, the counters and control bytes hold still.
- R2: After reset, both counters read 0xFFFF, both control bytes read 0x00, both flags and both pin enables are 0, and both latches hold 0x0001.
- R3: Write addresses are as follows. Timer A uses 0 (latch low), 1 (latch high) and 2 (control). Timer B uses 4 (latch low), 5 (latch high) and 6 (control). A low-byte write changes only the latch. A high-byte write while control bit 0 is clear copies the full new latch into the counter at that edge.
- R4: A control byte written at edge W appears on the control readback and takes effect at the first enabled edge after W. Bit 4 (force load) is never stored and reads back 0.
- R5: When control bit 0 (run) starts a stopped timer, the counter holds its value for one more enabled edge. It then decrements by one on each enabled edge. A continuous timer with latch L underflows every L+1 enabled edges.
- R6: On underflow from 1, the counter takes the latch value and the flag is 1 for one cycle. On the next enabled edge the counter stays at the latch value with no decrement.
- R7: When control bit 3 (one-shot) is set, underflow clears run bit 0. The counter then stays at the latch value.
- R8: A force load applied to a running timer loads the latch into the counter on the next enabled edge. Counting resumes one edge after that.
- R9: A force load with start, applied while the counter holds 1, counts as an underflow: the flag rises on the following enabled edge.
- R10: A running counter at 0 underflows on its next counting edge, reloading without passing through 0xFFFF.
- R11: Control bits 6:5 select the count source, and a write updates them at once. 00 counts every enabled cycle. 10 counts once per timer A underflow, which for timer A itself never happens. Other values never count.
- R12: Control bit 1 enables the pin (A drives `pb_out[0]`, B drives `pb_out[1]`, shown on `pb_oe`). With bit 2 clear, the pin is 1 for exactly the cycle after an underflow.
- R13: With bit 2 set, the pin shows a toggle level. The level is forced to 1 when the timer starts from stopped, and it inverts on every underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Enable that advances the timers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data byte |
| a_count | output | 16 | Timer A counter value |
| b_count | output | 16 | Timer B counter value |
| a_ctrl | output | 8 | Timer A applied control byte |
| b_ctrl | output | 8 | Timer B applied control byte |
| a_uflow | output | 1 | Timer A underflow flag, one cycle |
| b_uflow | output | 1 | Timer B underflow flag, one cycle |
| pb_out | output | 2 | Timer pin levels, bit 0 from A, bit 1 from B |
| pb_oe | output | 2 | Timer pin enables |

## Verification
The reload properties assume that no latch high-byte write lands on the same edge as an underflow. They also assume that the hold property's quiet cycles contain no write at all. The directed scenarios meet both conditions: they program every latch while the timers are stopped, before the run bit is set, and they lower `tick_en` only in a stretch with no writes. The one-shot and toggle properties need nothing from the inputs beyond a clean reset.

// File: rtl/dit_pkg.sv
// dit_pkg: shared widths, control bit positions, register sub-addresses
// and the sequencing states of one interval timer.
package dit_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int NUM_TMR = 2;
    localparam int SUB_W  = 2;
    localparam int IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
    localparam int ADDR_W = SUB_W + IDX_W;

    // control byte bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_PIN  = 1;
    localparam int CB_TOG  = 2;
    localparam int CB_ONE  = 3;
    localparam int CB_FLD  = 4;
    localparam int CB_SRC0 = 5;
    localparam int CB_SRC1 = 6;

    // sub-address within one timer's register group
    localparam logic [SUB_W-1:0] SUB_LO  = 2'd0;
    localparam logic [SUB_W-1:0] SUB_HI  = 2'd1;
    localparam logic [SUB_W-1:0] SUB_CTL = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,       // stopped
        ST_ARM,        // one idle cycle, then run
        ST_LOAD_IDLE,  // reload, then stop
        ST_LOAD_RUN,   // reload, then run
        ST_LOAD_ARM,   // reload (or fire at 1), then arm
        ST_RUN,        // decrementing
        ST_RUN_LAST    // one last decrement, then stop
    } tmr_state_e;
endpackage

// File: rtl/dit_regdec.sv
// dit_regdec: decodes a byte write into per-timer strobes.
// Assumes: upper address bits select the timer, low SUB_W bits the register.
module dit_regdec
    import dit_pkg::*;
#(
    parameter int NT = NUM_TMR
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NT-1:0]     lo_we,
    output logic [NT-1:0]     hi_we,
    output logic [NT-1:0]     ctl_we
);
    localparam int IW = ADDR_W - SUB_W;

    logic [SUB_W-1:0] sub;
    assign sub = wr_addr[SUB_W-1:0];

    for (genvar i = 0; i < NT; i++) begin : g_dec
        logic hit;
        // select this timer's register group
        assign hit       = wr_en && (wr_addr[ADDR_W-1:SUB_W] == IW'(i));
        assign lo_we[i]  = hit && (sub == SUB_LO);
        assign hi_we[i]  = hit && (sub == SUB_HI);
        assign ctl_we[i] = hit && (sub == SUB_CTL);
    end
endmodule

// File: rtl/dit_timer.sv
// dit_timer: one 16-bit interval timer with latch, delayed control
// write and cycle-exact start/stop/force-load sequencing.
// Assumes: tick_en qualifies every state change; chain_tick is the
// same-cycle underflow of the previous timer (0 for the first one).
module dit_timer
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              chain_tick,
    output logic [CNT_W-1:0]  count_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  latch_o,
    output logic              flag_o,
    output logic              toggle_o,
    output logic              underflow_o
);
    tmr_state_e        state_q, st_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, latch_q;
    logic [DATA_W-1:0] ctrl_q, ctrl_n, pend_q, pend_n;
    logic              pvld_q, pvld_n, tog_q, tog_n, flag_q;
    logic [1:0]        src_q;
    logic              src_ok, do_cnt, fire, cnt_uf;

    // count source: 00 every cycle, 10 previous timer underflow
    assign src_ok = (src_q == 2'b00) || ((src_q == 2'b10) && chain_tick);

    // next-state: sequencing, counting, underflow, delayed control apply
    always_comb begin
        st_n   = state_q;
        cnt_n  = cnt_q;
        ctrl_n = ctrl_q;
        pend_n = pend_q;
        pvld_n = pvld_q;
        tog_n  = tog_q;
        do_cnt = 1'b0;
        fire   = 1'b0;
        cnt_uf = 1'b0;
        if (tick_en) begin
            case (state_q)
                ST_ARM:       st_n = ST_RUN;
                ST_LOAD_IDLE: begin st_n = ST_IDLE; cnt_n = latch_q; end
                ST_LOAD_RUN:  begin st_n = ST_RUN;  cnt_n = latch_q; end
                ST_LOAD_ARM: begin
                    st_n = ST_ARM;
                    if (cnt_q == CNT_W'(1)) fire = 1'b1;
                    else                    cnt_n = latch_q;
                end
                ST_RUN:       do_cnt = 1'b1;
                ST_RUN_LAST:  begin st_n = ST_IDLE; do_cnt = 1'b1; end
                default:      ;
            endcase
            if (do_cnt && src_ok) begin
                if (cnt_q <= CNT_W'(1)) begin
                    cnt_n  = '0;
                    cnt_uf = 1'b1;
                    if (st_n != ST_IDLE) fire = 1'b1;
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            if (fire) begin
                cnt_n = latch_q;
                tog_n = !tog_q;
                if (ctrl_q[CB_ONE]) begin
                    ctrl_n[CB_RUN] = 1'b0;
                    pend_n[CB_RUN] = 1'b0;
                    st_n = ST_LOAD_IDLE;
                end else begin
                    st_n = ST_LOAD_RUN;
                end
            end
            if (pvld_q) begin
                case (st_n)
                    ST_IDLE, ST_LOAD_IDLE: begin
                        if (pend_n[CB_RUN]) begin
                            tog_n = 1'b1;
                            st_n  = pend_n[CB_FLD] ? ST_LOAD_ARM : ST_ARM;
                        end else if (pend_n[CB_FLD]) begin
                            st_n = ST_LOAD_IDLE;
                        end
                    end
                    ST_RUN: begin
                        if (pend_n[CB_RUN]) begin
                            if (pend_n[CB_FLD]) st_n = ST_LOAD_ARM;
                        end else begin
                            st_n = pend_n[CB_FLD] ? ST_LOAD_IDLE : ST_RUN_LAST;
                        end
                    end
                    ST_LOAD_RUN, ST_ARM: begin
                        if (pend_n[CB_RUN]) begin
                            if (pend_n[CB_ONE]) begin
                                pend_n[CB_RUN] = 1'b0;
                                st_n = ST_IDLE;
                            end else if (pend_n[CB_FLD]) begin
                                st_n = ST_LOAD_ARM;
                            end
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                    default: ;
                endcase
                ctrl_n         = pend_n;
                ctrl_n[CB_FLD] = 1'b0;
                pvld_n         = 1'b0;
            end
        end
        if (ctl_we) begin
            pend_n = wr_data;
            pvld_n = 1'b1;
        end
        if (hi_we && !ctrl_q[CB_RUN]) cnt_n = {wr_data, latch_q[DATA_W-1:0]};
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '1;
            ctrl_q  <= '0;
            pend_q  <= '0;
            pvld_q  <= 1'b0;
            tog_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= st_n;
            cnt_q   <= cnt_n;
            ctrl_q  <= ctrl_n;
            pend_q  <= pend_n;
            pvld_q  <= pvld_n;
            tog_q   <= tog_n;
            flag_q  <= fire;
        end
    end

    // latch bytes and the immediately applied source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= CNT_W'(1);
            src_q   <= 2'b00;
        end else begin
            if (lo_we) latch_q[DATA_W-1:0]     <= wr_data;
            if (hi_we) latch_q[CNT_W-1:DATA_W] <= wr_data;
            if (ctl_we) src_q <= {wr_data[CB_SRC1], wr_data[CB_SRC0]};
        end
    end

    assign count_o     = cnt_q;
    assign ctrl_o      = ctrl_q;
    assign latch_o     = latch_q;
    assign flag_o      = flag_q;
    assign toggle_o    = tog_q;
    assign underflow_o = cnt_uf;
endmodule

// File: rtl/dit_pin_mux.sv
// dit_pin_mux: selects pulse or toggle level for each timer's port pin.
// Assumes: pulse is the registered one-cycle underflow flag.
module dit_pin_mux #(
    parameter int NT = 2
) (
    input  logic [NT-1:0] pin_en,
    input  logic [NT-1:0] tog_mode,
    input  logic [NT-1:0] pulse,
    input  logic [NT-1:0] tog,
    output logic [NT-1:0] pb_out,
    output logic [NT-1:0] pb_oe
);
    for (genvar i = 0; i < NT; i++) begin : g_pin
        // drive the chosen level only while the pin is routed
        assign pb_out[i] = pin_en[i] && (tog_mode[i] ? tog[i] : pulse[i]);
        assign pb_oe[i]  = pin_en[i];
    end
endmodule

// File: rtl/dual_interval_timer.sv
// dual_interval_timer: two interval timers, B cascadable onto A's
// underflow, with byte-wide register writes and per-timer pin output.
// Assumes: one register write per cycle; tick_en is the system enable.
module dual_interval_timer
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  a_count,
    output logic [CNT_W-1:0]  b_count,
    output logic [DATA_W-1:0] a_ctrl,
    output logic [DATA_W-1:0] b_ctrl,
    output logic              a_uflow,
    output logic              b_uflow,
    output logic [NUM_TMR-1:0] pb_out,
    output logic [NUM_TMR-1:0] pb_oe
);
    logic [NUM_TMR-1:0] lo_we, hi_we, ctl_we;
    logic [NUM_TMR-1:0] flag_w, tog_w, uf_now_w, chain_w, pin_en_w, tog_mode_w;
    logic [CNT_W-1:0]   cnt_w   [NUM_TMR];
    logic [CNT_W-1:0]   latch_w [NUM_TMR];
    logic [DATA_W-1:0]  ctrl_w  [NUM_TMR];

    dit_regdec #(.NT(NUM_TMR)) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .lo_we  (lo_we),
        .hi_we  (hi_we),
        .ctl_we (ctl_we)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        // each timer chains onto its predecessor; the first has none
        if (i == 0) begin : g_head
            assign chain_w[i] = 1'b0;
        end else begin : g_link
            assign chain_w[i] = uf_now_w[i-1];
        end

        dit_timer u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_en    (tick_en),
            .lo_we      (lo_we[i]),
            .hi_we      (hi_we[i]),
            .ctl_we     (ctl_we[i]),
            .wr_data    (wr_data),
            .chain_tick (chain_w[i]),
            .count_o    (cnt_w[i]),
            .ctrl_o     (ctrl_w[i]),
            .latch_o    (latch_w[i]),
            .flag_o     (flag_w[i]),
            .toggle_o   (tog_w[i]),
            .underflow_o(uf_now_w[i])
        );

        assign pin_en_w[i]   = ctrl_w[i][CB_PIN];
        assign tog_mode_w[i] = ctrl_w[i][CB_TOG];
    end

    dit_pin_mux #(.NT(NUM_TMR)) u_pin (
        .pin_en  (pin_en_w),
        .tog_mode(tog_mode_w),
        .pulse   (flag_w),
        .tog     (tog_w),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe)
    );

    assign a_count = cnt_w[0];
    assign b_count = cnt_w[1];
    assign a_ctrl  = ctrl_w[0];
    assign b_ctrl  = ctrl_w[1];
    assign a_uflow = flag_w[0];
    assign b_uflow = flag_w[1];
endmodule

// File: rtl/dit_checker.sv
// dit_checker: temporal properties of dual_interval_timer, bound to it.
module dit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        wr_en,
    input logic [15:0] a_count,
    input logic [15:0] b_count,
    input logic [7:0]  a_ctrl,
    input logic [7:0]  b_ctrl,
    input logic        a_uflow,
    input logic        b_uflow,
    input logic [15:0] a_latch,
    input logic [15:0] b_latch,
    input logic        b_uf_now,
    input logic [1:0]  pb_out
);
    p_hold_when_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> ($stable(a_count) && $stable(a_ctrl) && $stable(b_count)));

    p_reload_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        a_uflow |-> (a_count == $past(a_latch)));

    p_reload_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b_uflow |-> (b_count == $past(b_latch)));

    p_end_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_uf_now && !wr_en) |=> ((b_count == $past(b_latch)) || (b_count == 16'h0000)));

    p_oneshot_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_uflow && a_ctrl[3]) |-> !a_ctrl[0]);

    p_toggle_flips_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (b_uflow && b_ctrl[1] && b_ctrl[2] && $past(b_ctrl[1] && b_ctrl[2]))
        |-> (pb_out[1] != $past(pb_out[1])));
endmodule

bind dual_interval_timer dit_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .a_count (a_count),
    .b_count (b_count),
    .a_ctrl  (a_ctrl),
    .b_ctrl  (b_ctrl),
    .a_uflow (a_uflow),
    .b_uflow (b_uflow),
    .a_latch (latch_w[0]),
    .b_latch (latch_w[1]),
    .b_uf_now(uf_now_w[1]),
    .pb_out  (pb_out)
);

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] a_count, b_count;
    logic [7:0]  a_ctrl, b_ctrl;
    logic        a_uflow, b_uflow;
    logic [1:0]  pb_out, pb_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .a_count(a_count),
        .b_count(b_count), .a_ctrl(a_ctrl), .b_ctrl(b_ctrl),
        .a_uflow(a_uflow), .b_uflow(b_uflow), .pb_out(pb_out), .pb_oe(pb_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b1; wr_en = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 a_count", a_count, 32'hFFFF);
        check("R2 b_count", b_count, 32'hFFFF);
        check("R2 ctrl", {a_ctrl, b_ctrl}, 32'h0);
        check("R2 flags", {a_uflow, b_uflow, pb_oe}, 32'h0);
        wr(3'd1, 8'h00);
        check("R2 latch low is 1", a_count, 32'h0001);
    endtask

    task automatic t_latch();
        do_reset();
        wr(3'd0, 8'h05);
        check("R3 low byte only latch", a_count, 32'hFFFF);
        wr(3'd1, 8'h00);
        check("R3 high byte loads", a_count, 32'h0005);
        wr(3'd4, 8'h34); wr(3'd5, 8'h12);
        check("R3 timer B load", b_count, 32'h1234);
    endtask

    task automatic t_start();
        do_reset();
        wr(3'd0, 8'h03); wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        check("R4 ctrl delayed", a_ctrl, 32'h00);
        step(1);
        check("R4 ctrl applied", a_ctrl, 32'h01);
        step(1); check("R5 idle cycle", a_count, 32'd3);
        step(1); check("R5 dec", a_count, 32'd2);
        step(1); check("R5 dec", a_count, 32'd1);
        step(1); check("R6 reload", a_count, 32'd3); check("R6 flag", a_uflow, 1);
        step(1); check("R6 gap", a_count, 32'd3); check("R6 flag one cycle", a_uflow, 0);
        step(1); check("R5 dec2", a_count, 32'd2);
        step(2); check("R5 period", a_uflow, 1);
    endtask

    task automatic t_force();
        do_reset();
        wr(3'd0, 8'h07); wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        step(4); check("R5 running", a_count, 32'd5);
        wr(3'd2, 8'h11);
        check("R8 still counting", a_count, 32'd4);
        step(1); check("R8 before load", a_count, 32'd3);
        check("R4 bit4 reads 0", a_ctrl, 32'h01);
        step(1); check("R8 loaded", a_count, 32'd7);
        step(1); check("R8 wait", a_count, 32'd7);
        step(1); check("R8 resumes", a_count, 32'd6);
    endtask

    task automatic t_force_one();
        do_reset();
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h11);
        check("R9 no flag yet", a_uflow, 0);
        step(1); check("R9 no flag yet", a_uflow, 0);
        step(1); check("R9 flag", a_uflow, 1); check("R9 count", a_count, 32'd1);
        step(1); check("R9 gap", a_uflow, 0);
        step(1); check("R9 again", a_uflow, 1);
    endtask

    task automatic t_oneshot();
        do_reset();
        wr(3'd0, 8'h02); wr(3'd1, 8'h00);
        wr(3'd2, 8'h09);
        step(3); check("R7 dec", a_count, 32'd1);
        step(1); check("R7 flag", a_uflow, 1); check("R7 run cleared", a_ctrl, 32'h08);
        step(6); check("R7 stopped", a_count, 32'd2); check("R7 no flag", a_uflow, 0);
        check("R7 ctrl", a_ctrl, 32'h08);
    endtask

    task automatic t_zero();
        do_reset();
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        step(2); check("R10 at zero", a_count, 32'd0); check("R10 no flag", a_uflow, 0);
        step(1); check("R10 flag", a_uflow, 1); check("R10 no wrap", a_count, 32'd0);
        step(1); check("R10 gap", a_uflow, 0);
        step(1); check("R10 again", a_uflow, 1);
    endtask

    task automatic t_chain();
        do_reset();
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h02); wr(3'd5, 8'h00);
        wr(3'd6, 8'h41);
        wr(3'd2, 8'h01);
        step(2); check("R11 B ignores cycles", b_count, 32'd2);
        step(1); check("R11 A underflow", a_uflow, 1); check("R11 B counts", b_count, 32'd1);
        step(1); check("R11 B holds", b_count, 32'd1);
        step(1); check("R11 B reload", b_count, 32'd2); check("R11 B flag", b_uflow, 1);
    endtask

    task automatic t_pins();
        do_reset();
        wr(3'd0, 8'h03); wr(3'd1, 8'h00);
        wr(3'd4, 8'h03); wr(3'd5, 8'h00);
        wr(3'd2, 8'h03);
        wr(3'd6, 8'h07);
        check("R12 A enabled B not", pb_oe, 32'b01);
        check("R12 pulse low", pb_out[0], 0);
        step(1); check("R13 start forces high", pb_out[1], 1); check("R12 B enabled", pb_oe, 32'b11);
        step(3); check("R12 pulse", pb_out[0], 1);
        step(1); check("R12 pulse ends", pb_out[0], 0); check("R13 flip low", pb_out[1], 0);
        step(4); check("R13 flip high", pb_out[1], 1); check("R12 pulse gone", pb_out[0], 0);
    endtask

    task automatic t_tick();
        do_reset();
        wr(3'd0, 8'h05); wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        step(3); check("R1 running", a_count, 32'd4);
        tick_en = 1'b0;
        step(5); check("R1 held", a_count, 32'd4); check("R1 no flag", a_uflow, 0);
        tick_en = 1'b1;
        step(1); check("R1 resumes", a_count, 32'd3);
    endtask

    initial begin
        t_reset();
        t_latch();
        t_start();
        t_force();
        t_force_one();
        t_oneshot();
        t_zero();
        t_chain();
        t_pins();
        t_tick();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule